// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a four-bank single-data-rate SDRAM from reset until the memory is ready for normal work. After reset it drives COMMAND INHIBIT until the clock-stable indication is first seen. It then holds NOP for a programmable number of cycles and precharges all banks. Next it issues exactly two auto-refresh commands and loads the mode register. Each of these commands is followed by its own gap of NOPs, counted in clock cycles.

When the gap after the mode-register load has run out, the block raises its init-done flag. From then on it keeps the bus at NOP, so that a normal-operation controller can take the bus over. All outputs are registered and change only on the rising clock edge. A synchronous reset restarts the whole sequence.

Command strobes are listed in the order chip-select, row strobe, column strobe, write enable, all active low. The codes are: NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. COMMAND INHIBIT is any code with chip-select high; this block drives 1111 for it.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: When rst is sampled high at a rising edge, that same edge drives COMMAND INHIBIT (1111), bank 00, address 0 and init-done low. A reset in the middle of the sequence restarts it from the start.
- R2: Until clk_stable_i is first sampled high after reset, every edge drives COMMAND INHIBIT (1111), bank 00 and address 0.
- R3: The first edge at which clk_stable_i is sampled high starts the wait. That edge and the following WAIT_CYC-1 edges drive NOP (0111), which is WAIT_CYC NOP cycles in all. Any later change of clk_stable_i has no effect until the next reset.
- R4: The edge right after the wait drives PRECHARGE (0010) for one cycle. It puts address bit 10 high (all banks), all other address bits 0, and bank 00.
- R5: Exactly two AUTO REFRESH commands (0001) follow, each with address 0 and bank 00. The first comes TRP_CYC cycles after the precharge and the second comes TRFC_CYC cycles after the first. Every cycle between commands is NOP.
- R6: LOAD MODE (0000) is issued TRFC_CYC cycles after the second refresh, with bank 00. The address carries the mode word: bits 2:0 burst-length code, bit 3 burst type (1 = interleaved), bits 6:4 CAS latency, bits 8:7 zero, bit 9 write mode (1 = single-location writes), bits 11:10 zero.
- R7: init_done_o rises TMRD_CYC cycles after the LOAD MODE edge and stays high until the next reset.
- R8: While init_done_o is high, the bus drives NOP (0111) with address 0 and bank 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable_i | input | 1 | Clock-stable indication; the first sample high starts the wait |
| cs_n_o | output | 1 | Chip-select strobe, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write-enable strobe, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Address bus; carries the all-banks bit and the mode word |
| init_done_o | output | 1 | High once the sequence is complete |

## Verification
Every output is due in the same rising edge that samples its cause. The first NOP appears in the edge that first samples clk_stable_i high, and each later command lands a fixed number of cycles after the edge that started the wait. That number is the sum of WAIT_CYC and the gaps that come before the command. The bench keeps its own cycle index from that starting edge and compares the whole bus against the expected value at each falling edge. Because inputs are driven just after a rising edge, each sample sees a settled result. The bench also logs every real command with its cycle, and after each run it checks the order and the exact spacing of the commands, including a run cut short by a mid-sequence reset.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_TRP,
    PH_TRFC1,
    PH_TRFC2,
    PH_TMRD,
    PH_READY
  } phase_t;

  typedef enum logic [2:0] {
    K_INH,
    K_NOP,
    K_PRE,
    K_REF,
    K_MRS
  } kind_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_INH = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic cmd_t kind_to_cmd(input kind_t k);
    cmd_t c;
    case (k)
      K_NOP:   c = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      K_PRE:   c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      K_REF:   c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      K_MRS:   c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: c = CMD_INH;
    endcase
    return c;
  endfunction

  // Mode word: [2:0] burst length, [3] burst type, [6:4] CAS latency,
  // [8:7] operating mode (zero), [9] write mode, [11:10] zero.
  function automatic logic [11:0] pack_mode(input logic [2:0] blen,
                                            input logic       intlv,
                                            input logic [2:0] cas_lat,
                                            input logic       wr_single);
    return {2'b00, wr_single, 2'b00, cas_lat, intlv, blen};
  endfunction

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WAIT_CYC = 40000,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 14,
  parameter int TMRD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_stable_i,
  input  logic             timer_exp,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output kind_t            kind_nxt,
  output logic             ready_nxt
);

  localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] TRFC_LD = CNT_W'(TRFC_CYC - 1);
  localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_CYC - 1);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    kind_nxt = K_NOP;
    case (phase_q)
      PH_IDLE: begin
        if (clk_stable_i) begin
          phase_d  = PH_WAIT;
          tmr_load = 1'b1;
          tmr_val  = WAIT_LD;
        end else begin
          kind_nxt = K_INH;
        end
      end
      PH_WAIT: begin
        if (timer_exp) begin
          phase_d  = PH_TRP;
          tmr_load = 1'b1;
          tmr_val  = TRP_LD;
          kind_nxt = K_PRE;
        end
      end
      PH_TRP: begin
        if (timer_exp) begin
          phase_d  = PH_TRFC1;
          tmr_load = 1'b1;
          tmr_val  = TRFC_LD;
          kind_nxt = K_REF;
        end
      end
      PH_TRFC1: begin
        if (timer_exp) begin
          phase_d  = PH_TRFC2;
          tmr_load = 1'b1;
          tmr_val  = TRFC_LD;
          kind_nxt = K_REF;
        end
      end
      PH_TRFC2: begin
        if (timer_exp) begin
          phase_d  = PH_TMRD;
          tmr_load = 1'b1;
          tmr_val  = TMRD_LD;
          kind_nxt = K_MRS;
        end
      end
      PH_TMRD: begin
        if (timer_exp) begin
          phase_d = PH_READY;
        end
      end
      PH_READY: begin
        phase_d = PH_READY;
      end
      default: begin
        phase_d  = PH_IDLE;
        kind_nxt = K_INH;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign ready_nxt = (phase_d == PH_READY);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                BA_W        = 2,
  parameter int                PRE_ALL_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  kind_t             kind_nxt,
  input  logic              ready_nxt,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);

  localparam logic [ADDR_W-1:0] PRE_ALL_WORD = ADDR_W'(1) << PRE_ALL_BIT;

  cmd_t              cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  always_comb begin
    case (kind_nxt)
      K_PRE:   addr_d = PRE_ALL_WORD;
      K_MRS:   addr_d = MODE_WORD;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_INH;
      addr_q  <= '0;
      ready_o <= 1'b0;
    end else begin
      cmd_q   <= kind_to_cmd(kind_nxt);
      addr_q  <= addr_d;
      ready_o <= ready_nxt;
    end
  end

  assign cs_n_o  = cmd_q.cs_n;
  assign ras_n_o = cmd_q.ras_n;
  assign cas_n_o = cmd_q.cas_n;
  assign we_n_o  = cmd_q.we_n;
  assign addr_o  = addr_q;
  assign ba_o    = '0;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int         WAIT_CYC         = 40000,
  parameter int         TRP_CYC          = 3,
  parameter int         TRFC_CYC         = 14,
  parameter int         TMRD_CYC         = 2,
  parameter logic [2:0] BURST_LEN_CODE   = 3'b010,
  parameter logic       BURST_INTERLEAVE = 1'b0,
  parameter logic [2:0] CAS_LAT          = 3'b011,
  parameter logic       WRITE_SINGLE     = 1'b0,
  parameter int         ADDR_W           = 12,
  parameter int         BA_W             = 2,
  parameter int         PRE_ALL_BIT      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_stable_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int MAX_GAP = max_of3(WAIT_CYC, (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC, TMRD_CYC);
  localparam int CNT_W   = cnt_width(MAX_GAP);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'(pack_mode(BURST_LEN_CODE, BURST_INTERLEAVE, CAS_LAT, WRITE_SINGLE));

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             timer_exp;
  kind_t            kind_nxt;
  logic             ready_nxt;

  // Named events for the checker
  logic ev_pre_issue, ev_ref_issue, ev_mrs_issue;
  assign ev_pre_issue = (kind_nxt == K_PRE);
  assign ev_ref_issue = (kind_nxt == K_REF);
  assign ev_mrs_issue = (kind_nxt == K_MRS);

  sdram_init_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (timer_exp)
  );

  sdram_init_fsm #(
    .CNT_W    (CNT_W),
    .WAIT_CYC (WAIT_CYC),
    .TRP_CYC  (TRP_CYC),
    .TRFC_CYC (TRFC_CYC),
    .TMRD_CYC (TMRD_CYC)
  ) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .clk_stable_i (clk_stable_i),
    .timer_exp    (timer_exp),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .kind_nxt     (kind_nxt),
    .ready_nxt    (ready_nxt)
  );

  sdram_cmd_drive #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .PRE_ALL_BIT (PRE_ALL_BIT),
    .MODE_WORD   (MODE_WORD)
  ) drive_i (
    .clk       (clk),
    .rst       (rst),
    .kind_nxt  (kind_nxt),
    .ready_nxt (ready_nxt),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .ba_o      (ba_o),
    .addr_o    (addr_o),
    .ready_o   (init_done_o)
  );

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
  parameter int                TRP_CYC     = 3,
  parameter int                TRFC_CYC    = 14,
  parameter int                TMRD_CYC    = 2,
  parameter int                ADDR_W      = 12,
  parameter int                BA_W        = 2,
  parameter int                PRE_ALL_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD   = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_stable_i,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done,
  input logic              ev_pre,
  input logic              ev_ref,
  input logic              ev_mrs
);

  logic [3:0] cmd;
  logic is_nop, is_pre, is_ref, is_mrs, is_real;
  assign cmd     = {cs_n, ras_n, cas_n, we_n};
  assign is_nop  = (cmd == 4'b0111);
  assign is_pre  = (cmd == 4'b0010);
  assign is_ref  = (cmd == 4'b0001);
  assign is_mrs  = (cmd == 4'b0000);
  assign is_real = !cs_n && !is_nop;

  logic       past_ok_q, seen_stable_q, pre_seen_q;
  logic [1:0] ref_cnt_q;
  int         gap_q;

  always_ff @(posedge clk) begin
    past_ok_q <= 1'b1;
    if (rst) begin
      seen_stable_q <= 1'b0;
      pre_seen_q    <= 1'b0;
      ref_cnt_q     <= 2'd0;
      gap_q         <= 0;
    end else begin
      if (clk_stable_i) seen_stable_q <= 1'b1;
      if (is_pre) pre_seen_q <= 1'b1;
      if (is_ref && ref_cnt_q != 2'd3) ref_cnt_q <= ref_cnt_q + 2'd1;
      if (is_real) gap_q <= 1;
      else if (gap_q < 32'h7fff_ffff) gap_q <= gap_q + 1;
    end
  end

  AST_RESET_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && $past(rst)) |-> (cs_n && !done && addr == '0 && ba == '0)); // R1
  AST_INHIBIT_UNSTABLE: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && !seen_stable_q) |-> cs_n); // R2
  AST_PRE_AFTER_STABLE: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> seen_stable_q); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (addr == (ADDR_W'(1) << PRE_ALL_BIT) && ba == '0)); // R4
  AST_PRE_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    ev_pre |=> is_pre); // R4
  AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (pre_seen_q && ref_cnt_q < 2'd2)); // R5
  AST_REF_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    ev_ref |=> is_ref); // R5
  AST_REF1_GAP: assert property (@(posedge clk) disable iff (rst)
    (is_ref && ref_cnt_q == 2'd0) |-> (gap_q == TRP_CYC)); // R5
  AST_REF2_GAP: assert property (@(posedge clk) disable iff (rst)
    (is_ref && ref_cnt_q == 2'd1) |-> (gap_q == TRFC_CYC)); // R5
  AST_MRS_ORDER: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (ref_cnt_q == 2'd2 && gap_q == TRFC_CYC && addr == MODE_WORD && ba == '0)); // R6
  AST_MRS_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    ev_mrs |=> is_mrs); // R6
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (gap_q == TMRD_CYC)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R7
  AST_NOP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (is_nop && addr == '0)); // R8

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
  .TRP_CYC     (TRP_CYC),
  .TRFC_CYC    (TRFC_CYC),
  .TMRD_CYC    (TMRD_CYC),
  .ADDR_W      (ADDR_W),
  .BA_W        (BA_W),
  .PRE_ALL_BIT (PRE_ALL_BIT),
  .MODE_WORD   (MODE_WORD)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .clk_stable_i (clk_stable_i),
  .cs_n         (cs_n_o),
  .ras_n        (ras_n_o),
  .cas_n        (cas_n_o),
  .we_n         (we_n_o),
  .ba           (ba_o),
  .addr         (addr_o),
  .done         (init_done_o),
  .ev_pre       (ev_pre_issue),
  .ev_ref       (ev_ref_issue),
  .ev_mrs       (ev_mrs_issue)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb_top;

  localparam int WAIT = 20;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;
  localparam int BL   = 3;
  localparam int BT   = 1;
  localparam int CL   = 2;
  localparam int WS   = 1;
  localparam int EXP_MODE = BL + BT * 8 + CL * 16 + WS * 512;
  localparam int T_PRE = WAIT;
  localparam int T_R1  = T_PRE + TRP;
  localparam int T_R2  = T_R1 + TRFC;
  localparam int T_M   = T_R2 + TRFC;
  localparam int T_D   = T_M + TMRD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_stable_i = 1'b0;
  logic        cs_n_o, ras_n_o, cas_n_o, we_n_o, init_done_o;
  logic [1:0]  ba_o;
  logic [11:0] addr_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sdram_pwrup_seq #(
    .WAIT_CYC(WAIT), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
    .BURST_LEN_CODE(3'(BL)), .BURST_INTERLEAVE(1'(BT)),
    .CAS_LAT(3'(CL)), .WRITE_SINGLE(1'(WS))
  ) dut_i (
    .clk(clk), .rst(rst), .clk_stable_i(clk_stable_i),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .init_done_o(init_done_o)
  );

  // Reference model: cycle index from the edge that first sees clock stable
  bit         model_valid = 0;
  bit         started = 0;
  bit         after_rst = 0;
  int         k = 0;
  logic [3:0] e_cmd = 4'hF;
  int         e_addr = 0;
  logic       e_done = 1'b0;
  string      e_tag = "R1";

  always @(posedge clk) begin
    cyc++;
    model_valid = 1;
    if (rst) begin
      started = 0; k = 0; after_rst = 1;
    end else if (!started) begin
      after_rst = 0;
      if (clk_stable_i) begin started = 1; k = 0; end
    end else begin
      after_rst = 0;
      k++;
    end
    e_addr = 0; e_done = 1'b0;
    if (!started) begin
      e_cmd = 4'hF; e_tag = after_rst ? "R1" : "R2";
    end else if (k < T_PRE) begin
      e_cmd = 4'b0111; e_tag = "R3";
    end else if (k == T_PRE) begin
      e_cmd = 4'b0010; e_addr = 1024; e_tag = "R4";
    end else if (k == T_R1 || k == T_R2) begin
      e_cmd = 4'b0001; e_tag = "R5";
    end else if (k == T_M) begin
      e_cmd = 4'b0000; e_addr = EXP_MODE; e_tag = "R6";
    end else begin
      e_cmd = 4'b0111;
      e_done = (k >= T_D);
      e_tag = (k < T_R2) ? "R5" : (k <= T_D) ? "R7" : "R8";
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL R7 watchdog expired: actual cycle %0d expected under 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int log_kind[$];
  int log_cyc[$];

  always @(negedge clk) begin
    logic [3:0] act;
    act = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    if (model_valid) begin
      checks++;
      if (act !== e_cmd || int'(addr_o) != e_addr || ba_o !== 2'b00 || init_done_o !== e_done) begin
        failures++;
        $display("FAIL %s k=%0d: actual cmd=%b addr=%h ba=%b done=%b expected cmd=%b addr=%h ba=00 done=%b",
                 e_tag, k, act, addr_o, ba_o, init_done_o, e_cmd, e_addr, e_done);
      end
      if (!cs_n_o && act != 4'b0111) begin
        log_kind.push_back(int'(act));
        log_cyc.push_back(cyc);
      end
    end
  end

  task automatic expect_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_order();
    expect_int("R5 command count", log_kind.size(), 4);
    if (log_kind.size() == 4) begin
      expect_int("R4 first command is precharge", log_kind[0], 2);
      expect_int("R5 second command is refresh", log_kind[1], 1);
      expect_int("R5 third command is refresh", log_kind[2], 1);
      expect_int("R6 fourth command is mode load", log_kind[3], 0);
      expect_int("R5 precharge to refresh gap", log_cyc[1] - log_cyc[0], TRP);
      expect_int("R5 refresh to refresh gap", log_cyc[2] - log_cyc[1], TRFC);
      expect_int("R6 refresh to mode load gap", log_cyc[3] - log_cyc[2], TRFC);
    end
    log_kind.delete();
    log_cyc.delete();
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1 reset, R2 inhibit while the clock is not yet stable
    step(3);
    rst = 1'b0;
    step(10);
    // R3 wait starts; later drops of clk_stable_i are ignored
    clk_stable_i = 1'b1;
    step(5);
    clk_stable_i = 1'b0;
    step(3);
    clk_stable_i = 1'b1;
    step(T_D + 20);
    check_order();
    // R1 mid-sequence reset restarts the whole sequence
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(T_R1 + 3);
    rst = 1'b1;
    log_kind.delete();
    log_cyc.delete();
    step(2);
    rst = 1'b0;
    step(T_D + 20);
    check_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule